// File: doc/BRIEF.md
# BCD Time-of-Day Alarm Comparator

This block keeps an alarm time made of four packed-BCD fields (second, minute, hour and day of month). It checks them against the running calendar values from a separate time counter each time a one-second tick arrives. When all four fields agree at a tick, a sticky alarm flag is latched. If the host has enabled it, an interrupt line is raised.

The host reaches the block through a byte-wide register port with a 3-bit address. A read from the flags register clears the alarm flag. A write to any alarm register clears a pending alarm, so a match against old alarm settings is not reported. A battery-backup input suppresses the interrupt line unless a separate backup enable is set. The flag itself is always latched.

A two-state machine holds the alarm flag. The states are `FL_IDLE` (no alarm pending) and `FL_PENDING` (alarm latched). There are two transitions:
- `FL_IDLE` to `FL_PENDING` ("hit") happens on a qualified match with no alarm-register write in the same cycle.
- `FL_PENDING` to `FL_IDLE` happens on either of two events:
  - "rearm": an alarm-register write.
  - "ack": a flags read with no match in the same cycle.

Top module: `alarm_match_unit`

Register addresses:

| Address | Register | Fields |
|---|---|---|
| 0 | Flags | bit 6 = alarm flag, bit 4 = battery low |
| 1 | Alarm second | BCD 00-59 |
| 2 | Alarm minute | BCD 00-59 |
| 3 | Alarm hour | BCD 00-23 |
| 4 | Alarm day of month | BCD 01-31 |
| 5 | Control | bit 7 = interrupt enable, bit 5 = backup interrupt enable |
| 6, 7 | Unused | read 0x00, writes ignored |

## Requirements
- R1: After reset, the registers read as follows: flags 0x00 (with battery low deasserted), alarm second, minute and hour 0x00, alarm day 0x01, control 0x00. `irq_o` is low.
- R2: Alarm second and minute keep bits 6:0 of the written byte. Alarm hour and day keep bits 5:0. Bits that are not kept read as 0. Writes to addresses 6 and 7 have no effect, and those addresses read 0x00.
- R3: The control register keeps only bit 7 (interrupt enable) and bit 5 (backup interrupt enable). All other bits read as 0.
- R4: When `tick_i` is high in a cycle where all four current-time inputs equal the alarm fields, flags bit 6 reads 1 from the next cycle. Bits outside each field's kept width are ignored in the comparison.
- R5: The flag is not set when there is no tick, or when any single field differs at the tick.
- R6: Once set, the flag stays set across later ticks that do not match.
- R7: Reading address 0 with `rd_en_i` high returns the flag and clears it at that clock edge. If a match occurs in the same cycle, the flag stays set.
- R8: A write to any of addresses 1 to 4 clears the flag, and this takes priority over a match in the same cycle. A write to the control register does not clear the flag.
- R9: Outside battery-backup mode, `irq_o` is high exactly when the flag is set and control bit 7 is 1.
- R10: While `batt_backup_i` is high and control bit 5 is 0, `irq_o` is low even though the flag is set. With bit 5 set, the interrupt follows R9.
- R11: Flags bit 4 reads `batt_low_i`. Flags bits 7, 5 and 3:0 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse, once per second |
| cur_sec_i | input | 8 | Current second, BCD |
| cur_min_i | input | 8 | Current minute, BCD |
| cur_hour_i | input | 8 | Current hour, BCD |
| cur_mday_i | input | 8 | Current day of month, BCD |
| batt_backup_i | input | 1 | High while running from battery |
| batt_low_i | input | 1 | Battery-low indication, shown in flags bit 4 |
| addr_i | input | 3 | Register address |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (read side effects) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from `addr_i` |
| irq_o | output | 1 | Alarm interrupt, active high |

## Verification
The assertions assume the following about the inputs:
- `tick_i` is a single-cycle pulse.
- `wr_en_i` and `rd_en_i` are never high together.
- Inputs change only away from the rising edge, so a strobe covers exactly one edge.

The bench drives every input on the falling edge and holds each strobe for one full period. It feeds only valid BCD time values, except where a test checks that bits outside a field's width are masked. It never combines a read and a write in one cycle.

// File: rtl/alm_pkg.sv
package alm_pkg;

    localparam int BYTE_W     = 8;
    localparam int REG_ADDR_W = 3;
    localparam int N_FIELDS   = 4;

    // Register addresses; fields occupy A_FIELD0 .. A_FIELD0+N_FIELDS-1
    localparam int A_FLAGS  = 0;
    localparam int A_FIELD0 = 1;
    localparam int A_CTRL   = A_FIELD0 + N_FIELDS;

    // Bit positions
    localparam int FLG_ALARM_BIT   = 6;
    localparam int FLG_BATTLOW_BIT = 4;
    localparam int CTL_IRQ_EN_BIT  = 7;
    localparam int CTL_BKP_EN_BIT  = 5;

    typedef enum logic {
        FL_IDLE    = 1'b0,
        FL_PENDING = 1'b1
    } flag_state_e;

    // Field index 0 second, 1 minute, 2 hour, 3 day of month
    function automatic logic [BYTE_W-1:0] field_mask(input int idx);
        return (idx < 2) ? 8'h7F : 8'h3F;
    endfunction

    function automatic logic [BYTE_W-1:0] field_reset(input int idx);
        return (idx == 3) ? 8'h01 : 8'h00;
    endfunction

endpackage

// File: rtl/alm_regs.sv
module alm_regs
    import alm_pkg::*;
#(
    parameter int DATA_W  = BYTE_W,
    parameter int ADDR_W  = REG_ADDR_W,
    parameter int NFIELDS = N_FIELDS
) (
    input  logic                           clk_i,
    input  logic                           rst_ni,
    input  logic [ADDR_W-1:0]              addr_i,
    input  logic                           wr_en_i,
    input  logic                           rd_en_i,
    input  logic [DATA_W-1:0]              wdata_i,
    input  logic                           flag_i,
    input  logic                           batt_low_i,
    output logic [NFIELDS-1:0][DATA_W-1:0] alarm_o,
    output logic                           irq_en_o,
    output logic                           bkp_en_o,
    output logic                           alarm_wr_o,
    output logic                           flags_rd_o,
    output logic [DATA_W-1:0]              rdata_o
);

    logic [NFIELDS-1:0][DATA_W-1:0] alarm_q;
    logic [NFIELDS-1:0]             field_hit;
    logic                           ctrl_hit;
    logic                           irq_en_q;
    logic                           bkp_en_q;

    for (genvar g = 0; g < NFIELDS; g++) begin : g_field
        assign field_hit[g] = (addr_i == ADDR_W'(A_FIELD0 + g));

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                alarm_q[g] <= field_reset(g);
            end else if (wr_en_i && field_hit[g]) begin
                alarm_q[g] <= wdata_i & field_mask(g);
            end
        end
    end

    assign ctrl_hit = (addr_i == ADDR_W'(A_CTRL));

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            irq_en_q <= 1'b0;
            bkp_en_q <= 1'b0;
        end else if (wr_en_i && ctrl_hit) begin
            irq_en_q <= wdata_i[CTL_IRQ_EN_BIT];
            bkp_en_q <= wdata_i[CTL_BKP_EN_BIT];
        end
    end

    assign alarm_o    = alarm_q;
    assign irq_en_o   = irq_en_q;
    assign bkp_en_o   = bkp_en_q;
    assign alarm_wr_o = wr_en_i && (|field_hit);
    assign flags_rd_o = rd_en_i && (addr_i == ADDR_W'(A_FLAGS));

    always_comb begin
        rdata_o = '0;
        if (addr_i == ADDR_W'(A_FLAGS)) begin
            rdata_o[FLG_ALARM_BIT]   = flag_i;
            rdata_o[FLG_BATTLOW_BIT] = batt_low_i;
        end else if (ctrl_hit) begin
            rdata_o[CTL_IRQ_EN_BIT] = irq_en_q;
            rdata_o[CTL_BKP_EN_BIT] = bkp_en_q;
        end else begin
            for (int i = 0; i < NFIELDS; i++) begin
                if (field_hit[i]) rdata_o = alarm_q[i];
            end
        end
    end

endmodule

// File: rtl/alm_cmp.sv
module alm_cmp
    import alm_pkg::*;
#(
    parameter int DATA_W  = BYTE_W,
    parameter int NFIELDS = N_FIELDS
) (
    input  logic                           tick_i,
    input  logic [NFIELDS-1:0][DATA_W-1:0] alarm_i,
    input  logic [NFIELDS-1:0][DATA_W-1:0] now_i,
    output logic                           match_o
);

    logic [NFIELDS-1:0] field_eq;

    for (genvar g = 0; g < NFIELDS; g++) begin : g_eq
        assign field_eq[g] = (alarm_i[g] == (now_i[g] & field_mask(g)));
    end

    assign match_o = tick_i && (&field_eq);

endmodule

// File: rtl/alm_flag_fsm.sv
module alm_flag_fsm
    import alm_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic match_i,
    input  logic alarm_wr_i,
    input  logic flags_rd_i,
    input  logic irq_en_i,
    input  logic bkp_en_i,
    input  logic batt_backup_i,
    output logic flag_o,
    output logic irq_o
);

    flag_state_e state_q, state_d;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= FL_IDLE;
        else         state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FL_IDLE: begin
                if (match_i && !alarm_wr_i) state_d = FL_PENDING;   // hit
            end
            FL_PENDING: begin
                if (alarm_wr_i)                   state_d = FL_IDLE; // rearm
                else if (flags_rd_i && !match_i)  state_d = FL_IDLE; // ack
            end
            default: state_d = FL_IDLE;
        endcase
    end

    always_comb begin
        flag_o = (state_q == FL_PENDING);
        irq_o  = flag_o && irq_en_i && (!batt_backup_i || bkp_en_i);
    end

endmodule

// File: rtl/alarm_match_unit.sv
module alarm_match_unit
    import alm_pkg::*;
#(
    parameter int DATA_W  = BYTE_W,
    parameter int ADDR_W  = REG_ADDR_W,
    parameter int NFIELDS = N_FIELDS
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic [DATA_W-1:0] cur_sec_i,
    input  logic [DATA_W-1:0] cur_min_i,
    input  logic [DATA_W-1:0] cur_hour_i,
    input  logic [DATA_W-1:0] cur_mday_i,
    input  logic              batt_backup_i,
    input  logic              batt_low_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              irq_o
);

    logic [NFIELDS-1:0][DATA_W-1:0] alarm_fields;
    logic [NFIELDS-1:0][DATA_W-1:0] now_fields;
    logic irq_en, bkp_en, alarm_wr, flags_rd, match_evt, alarm_flag;

    assign now_fields = {cur_mday_i, cur_hour_i, cur_min_i, cur_sec_i};

    alm_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NFIELDS(NFIELDS)) u_regs (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .addr_i     (addr_i),
        .wr_en_i    (wr_en_i),
        .rd_en_i    (rd_en_i),
        .wdata_i    (wdata_i),
        .flag_i     (alarm_flag),
        .batt_low_i (batt_low_i),
        .alarm_o    (alarm_fields),
        .irq_en_o   (irq_en),
        .bkp_en_o   (bkp_en),
        .alarm_wr_o (alarm_wr),
        .flags_rd_o (flags_rd),
        .rdata_o    (rdata_o)
    );

    alm_cmp #(.DATA_W(DATA_W), .NFIELDS(NFIELDS)) u_cmp (
        .tick_i  (tick_i),
        .alarm_i (alarm_fields),
        .now_i   (now_fields),
        .match_o (match_evt)
    );

    alm_flag_fsm u_fsm (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .match_i       (match_evt),
        .alarm_wr_i    (alarm_wr),
        .flags_rd_i    (flags_rd),
        .irq_en_i      (irq_en),
        .bkp_en_i      (bkp_en),
        .batt_backup_i (batt_backup_i),
        .flag_o        (alarm_flag),
        .irq_o         (irq_o)
    );

endmodule

// File: rtl/alm_chk.sv
module alm_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       match_evt,
    input logic       alarm_wr,
    input logic       flags_rd,
    input logic       alarm_flag,
    input logic       irq_en,
    input logic       bkp_en,
    input logic       batt_backup_i,
    input logic       batt_low_i,
    input logic [2:0] addr_i,
    input logic [7:0] rdata_o,
    input logic       irq_o
);

    // R4
    match_sets_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (match_evt && !alarm_wr) |=> alarm_flag);

    // R5
    flag_needs_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(alarm_flag) |-> $past(match_evt));

    // R6
    flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (alarm_flag && !flags_rd && !alarm_wr) |=> alarm_flag);

    // R7
    read_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (alarm_flag && flags_rd && !match_evt && !alarm_wr) |=> !alarm_flag);

    // R8
    write_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        alarm_wr |=> !alarm_flag);

    // R9
    irq_needs_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> (alarm_flag && irq_en));

    // R10
    backup_mutes_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (batt_backup_i && !bkp_en) |-> !irq_o);

    // R11
    battlow_visible_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (addr_i == 3'd0) |-> (rdata_o[4] == batt_low_i && rdata_o[6] == alarm_flag));

endmodule

bind alarm_match_unit alm_chk u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .match_evt     (match_evt),
    .alarm_wr      (alarm_wr),
    .flags_rd      (flags_rd),
    .alarm_flag    (alarm_flag),
    .irq_en        (irq_en),
    .bkp_en        (bkp_en),
    .batt_backup_i (batt_backup_i),
    .batt_low_i    (batt_low_i),
    .addr_i        (addr_i),
    .rdata_o       (rdata_o),
    .irq_o         (irq_o)
);

// File: tb/alarm_match_unit_bench.sv
module alarm_match_unit_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [7:0] c_sec = 8'h00, c_min = 8'h00, c_hour = 8'h00, c_mday = 8'h01;
    logic       bkp = 1'b0, blow = 1'b0;
    logic [2:0] addr = 3'd0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       irq;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    alarm_match_unit u_alarm_match_unit (
        .clk_i(clk), .rst_ni(rst_n), .tick_i(tick),
        .cur_sec_i(c_sec), .cur_min_i(c_min), .cur_hour_i(c_hour), .cur_mday_i(c_mday),
        .batt_backup_i(bkp), .batt_low_i(blow),
        .addr_i(addr), .wr_en_i(wr_en), .rd_en_i(rd_en), .wdata_i(wdata),
        .rdata_o(rdata), .irq_o(irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic host_wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    // look at a register without side effects
    task automatic peek(input logic [2:0] a, output logic [7:0] d);
        addr = a; #1; d = rdata;
    endtask

    task automatic host_rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk); addr = a; rd_en = 1'b1; #1; d = rdata;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic set_now(input logic [7:0] s, input logic [7:0] m,
                           input logic [7:0] h, input logic [7:0] dm);
        c_sec = s; c_min = m; c_hour = h; c_mday = dm;
    endtask

    task automatic pulse_tick();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
    endtask

    task automatic arm(input logic [7:0] s, input logic [7:0] m,
                       input logic [7:0] h, input logic [7:0] dm);
        host_wr(3'd1, s); host_wr(3'd2, m); host_wr(3'd3, h); host_wr(3'd4, dm);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        peek(3'd0, d); check("R1 flags", d, 8'h00);
        peek(3'd1, d); check("R1 alarm sec", d, 8'h00);
        peek(3'd2, d); check("R1 alarm min", d, 8'h00);
        peek(3'd3, d); check("R1 alarm hour", d, 8'h00);
        peek(3'd4, d); check("R1 alarm day", d, 8'h01);
        peek(3'd5, d); check("R1 control", d, 8'h00);
        check("R1 irq", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_regs();
        logic [7:0] d;
        host_wr(3'd1, 8'hFF); peek(3'd1, d); check("R2 sec mask", d, 8'h7F);
        host_wr(3'd2, 8'hD9); peek(3'd2, d); check("R2 min mask", d, 8'h59);
        host_wr(3'd3, 8'hFF); peek(3'd3, d); check("R2 hour mask", d, 8'h3F);
        host_wr(3'd4, 8'hF1); peek(3'd4, d); check("R2 day mask", d, 8'h31);
        host_wr(3'd6, 8'hFF); peek(3'd6, d); check("R2 unused 6", d, 8'h00);
        host_wr(3'd7, 8'hFF); peek(3'd7, d); check("R2 unused 7", d, 8'h00);
        peek(3'd1, d); check("R2 sec untouched", d, 8'h7F);
        host_wr(3'd5, 8'hFF); peek(3'd5, d); check("R3 ctrl bits", d, 8'hA0);
        host_wr(3'd5, 8'h5F); peek(3'd5, d); check("R3 ctrl others", d, 8'h00);
    endtask

    task automatic t_match();
        logic [7:0] d;
        arm(8'h45, 8'h30, 8'h12, 8'h15);
        set_now(8'h45, 8'h30, 8'h12, 8'h15);
        repeat (3) @(negedge clk);
        peek(3'd0, d); check("R5 no tick", d, 8'h00);
        pulse_tick();
        peek(3'd0, d); check("R4 match", d, 8'h40);
        host_rd(3'd0, d);
        // upper bits outside the field width ignored
        set_now(8'hC5, 8'hB0, 8'hD2, 8'hD5);
        pulse_tick();
        peek(3'd0, d); check("R4 masked match", d, 8'h40);
        host_rd(3'd0, d);
        for (int f = 0; f < 4; f++) begin
            set_now(f == 0 ? 8'h46 : 8'h45, f == 1 ? 8'h31 : 8'h30,
                    f == 2 ? 8'h13 : 8'h12, f == 3 ? 8'h16 : 8'h15);
            pulse_tick();
            peek(3'd0, d); check("R5 one field differs", d, 8'h00);
        end
    endtask

    task automatic t_sticky_read();
        logic [7:0] d;
        set_now(8'h45, 8'h30, 8'h12, 8'h15);
        pulse_tick();
        set_now(8'h46, 8'h30, 8'h12, 8'h15);
        pulse_tick(); pulse_tick();
        peek(3'd0, d); check("R6 sticky", d, 8'h40);
        host_rd(3'd0, d); check("R7 read returns flag", d, 8'h40);
        peek(3'd0, d); check("R7 cleared by read", d, 8'h00);
        // read coincides with a match: flag survives
        set_now(8'h45, 8'h30, 8'h12, 8'h15);
        pulse_tick();
        @(negedge clk); addr = 3'd0; rd_en = 1'b1; tick = 1'b1;
        @(negedge clk); rd_en = 1'b0; tick = 1'b0;
        peek(3'd0, d); check("R7 match beats read", d, 8'h40);
    endtask

    task automatic t_write_clear();
        logic [7:0] d;
        host_wr(3'd5, 8'h80);
        peek(3'd0, d); check("R8 ctrl write keeps flag", d, 8'h40);
        host_wr(3'd3, 8'h12);
        peek(3'd0, d); check("R8 alarm write clears", d, 8'h00);
        @(negedge clk); addr = 3'd1; wdata = 8'h45; wr_en = 1'b1; tick = 1'b1;
        @(negedge clk); wr_en = 1'b0; tick = 1'b0;
        peek(3'd0, d); check("R8 write beats match", d, 8'h00);
    endtask

    task automatic t_irq();
        logic [7:0] d;
        host_wr(3'd5, 8'h00);
        pulse_tick();
        #1; check("R9 irq off when disabled", {7'd0, irq}, 8'h00);
        host_wr(3'd5, 8'h80);
        #1; check("R9 irq on", {7'd0, irq}, 8'h01);
        bkp = 1'b1; #1;
        check("R10 backup mutes irq", {7'd0, irq}, 8'h00);
        peek(3'd0, d); check("R10 flag kept in backup", d, 8'h40);
        host_wr(3'd5, 8'hA0);
        #1; check("R10 backup enable", {7'd0, irq}, 8'h01);
        bkp = 1'b0;
        host_rd(3'd0, d);
        #1; check("R9 irq drops after clear", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_battlow();
        logic [7:0] d;
        blow = 1'b1;
        peek(3'd0, d); check("R11 battery low bit", d, 8'h10);
        blow = 1'b0;
        peek(3'd0, d); check("R11 battery low clear", d, 8'h00);
    endtask

    initial begin
        #200000;
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_match();
        t_sticky_read();
        t_write_clear();
        t_irq();
        t_battlow();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule